// File: doc/BRIEF.md
# Dual-Domain Deep Sleep Entry Controller

This controller decides when a system built around two processor domains may drop into its system-wide deep sleep state, and it walks the hardware through entry and exit. Each domain reports its current low-power mode: run, wait or stop. A small configuration register supplies a global deep-sleep enable, a fast-wake-up-stop enable per domain and a trigger mask per domain. A status input reports whether every clock generator is shut down. Deep sleep is requested only when the domains that count are in the ordinary stop form, which is the form that is not fast-wake-up. A domain in fast-wake-up stop keeps the run supply level and leaves clock handling to software, so it never counts toward entry.

Once a request is seen, the controller gates the clocks. It then waits a fixed settle count and asks for the low supply level. It declares the system asleep when the supply reports that it has reached the low level. An enabled wake-up event reverses this order: the supply goes back up first, and the clocks are released only after the supply reports that it has left the low level. A trigger mask lets one domain alone bring the system down. A configuration write that would set both masks is refused and recorded in a sticky error flag.

Top module: `dsm_entry_ctrl`

## Requirements
- R1: After reset, `dsm_req`, `clk_off`, `supply_low`, `asleep` and `cfg_err` are 0 and `cfg_q` reads 0. The reset clears every enable and mask, so the non-fast-wake-up form is the default.
- R2: Mode codes are 0 = run, 1 = wait, 2 = stop; any other code is treated as run. The configuration bits are: bit0 global enable, bit1 fast-wake-up-stop enable of domain A, bit2 the same for domain B, bit3 mask on A, bit4 mask on B. With no mask set, `dsm_req` is 1 when both domains report stop, both fast-wake-up bits are 0, bit0 is 1 and `plls_off` is 1.
- R3: A domain that reports stop while its fast-wake-up bit is 1 does not count as stopped, so no request is raised on its account.
- R4: `dsm_req` stays 0 while `plls_off` is 0, whatever the modes and the configuration.
- R5: With bit4 set, domain A in non-fast-wake-up stop alone raises the request, whatever the mode of B. Bit3 gives the mirror case, where domain B alone raises it.
- R6: A write whose data has bit3 and bit4 both set leaves `cfg_q` unchanged and sets `cfg_err`. `cfg_err` stays set until reset. Bit3 and bit4 of `cfg_q` are never both 1.
- R7: `clk_off` rises one cycle after the first edge that sees `dsm_req`. `supply_low` rises after `SETTLE` cycles of gating. `asleep` rises one cycle after the edge that sees `vsup_at_low` high while the supply is being lowered.
- R8: If `dsm_req` falls while the clocks are gated but before the supply is lowered, `clk_off` returns to 0 one cycle later and the supply is never lowered.
- R9: While asleep, a wake event whose `wake_en` bit is 0 has no effect. An enabled event clears `asleep` and `supply_low` one cycle later. `clk_off` falls only one cycle after the edge that sees `vsup_at_low` low.
- R10: With no mask set, a domain reporting run or wait keeps `dsm_req` at 0 even while the other domain is in non-fast-wake-up stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_a | input | 2 | Low-power mode reported by domain A |
| mode_b | input | 2 | Low-power mode reported by domain B |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration write data |
| cfg_q | output | 5 | Current configuration |
| cfg_err | output | 1 | Sticky flag set by a refused write that had both masks |
| plls_off | input | 1 | All clock generators report closed |
| vsup_at_low | input | 1 | Supply reports it sits at the deep-sleep level |
| wake_evt | input | WAKE_W | Wake-up event lines |
| wake_en | input | WAKE_W | Per-line wake-up enables |
| dsm_req | output | 1 | Deep sleep entry condition currently met |
| clk_off | output | 1 | Clock gating command |
| supply_low | output | 1 | Request for the deep-sleep supply level |
| asleep | output | 1 | System is in deep sleep |

## Verification
The hardest situation to reach is the exit window. Here the supply has been asked back up, but it still reports the low level, and the clocks must remain gated. The stimulus uses a supply stand-in that follows `supply_low` two cycles late. An override holds that stand-in at the low level across a wake event, which keeps the window open for several cycles. A second hard case is abandoning entry during the gating phase. The stimulus reaches it by moving a domain back to run a couple of cycles after the request appears, which is shorter than the settle count.

// File: rtl/dsm_pkg.sv
// Shared types for the deep sleep entry controller.
// Assumes a two-bit mode code per domain and a five-bit configuration word.
package dsm_pkg;
    localparam int CFG_W = 5;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_STOP = 2'd2
    } pmode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GATE,
        SQ_LOWER,
        SQ_SLEEP,
        SQ_RAISE
    } seq_e;

    // bit0 enable, bit1/bit2 fast-wake-up per domain, bit3/bit4 masks
    typedef struct packed {
        logic msk_b;
        logic msk_a;
        logic fw_b;
        logic fw_a;
        logic en;
    } cfg_t;
endpackage

// File: rtl/dsm_cfg_regs.sv
// Configuration register with the two-mask exclusion rule.
// A write that sets both masks is dropped whole and flags a sticky error.
// Assumes a single writer; no read strobe is needed.
module dsm_cfg_regs
    import dsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic             err
);
    cfg_t wcfg;
    logic bad_wr;

    // decode the write word and spot a forbidden combination
    always_comb begin
        wcfg   = cfg_t'(wdata);
        bad_wr = wcfg.msk_a && wcfg.msk_b;
    end

    // hold the configuration and the sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            err <= 1'b0;
        end else if (we) begin
            if (bad_wr) err <= 1'b1;
            else        cfg <= wcfg;
        end
    end

    // R6
    mask_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg.msk_a && cfg.msk_b));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/dsm_trigger.sv
// Combinational entry condition for the two domains.
// A domain counts as stopped only in the non-fast-wake-up stop form.
// Assumes the mode inputs are already synchronous to clk.
module dsm_trigger
    import dsm_pkg::*;
#(
    parameter int N_DOM = 2
) (
    input  logic [N_DOM-1:0][1:0] mode,
    input  logic [N_DOM-1:0]      fw_en,
    input  logic [N_DOM-1:0]      mask,
    input  logic                  en,
    input  logic                  plls_off,
    output logic                  req
);
    logic [N_DOM-1:0] nfw_stop;
    logic [N_DOM-1:0] counts;

    // per-domain stop qualification; a masked domain no longer has to be stopped
    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        always_comb begin
            nfw_stop[d] = (mode[d] == PM_STOP) && !fw_en[d];
            counts[d]   = nfw_stop[d] || mask[d];
        end
    end

    // at least one real stopped domain must be present
    always_comb req = en && plls_off && (&counts) && (|nfw_stop);
endmodule

// File: rtl/dsm_seq.sv
// Entry and exit sequencer: gate clocks, settle, lower supply, sleep, and the reverse.
// Assumes vsup_at_low is a level that follows supply_low with some delay.
module dsm_seq
    import dsm_pkg::*;
#(
    parameter int SETTLE = 4,
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              vsup_at_low,
    input  logic [WAKE_W-1:0] wake_evt,
    input  logic [WAKE_W-1:0] wake_en,
    output logic              clk_off,
    output logic              supply_low,
    output logic              asleep
);
    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

    seq_e             st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic             wake_hit;

    // choose the next phase
    always_comb begin
        wake_hit = |(wake_evt & wake_en);
        st_nx    = st;
        unique case (st)
            SQ_IDLE:  if (req) st_nx = SQ_GATE;
            SQ_GATE:  if (!req) st_nx = SQ_IDLE;
                      else if (cnt == CNT_LAST) st_nx = SQ_LOWER;
            SQ_LOWER: if (vsup_at_low) st_nx = SQ_SLEEP;
            SQ_SLEEP: if (wake_hit) st_nx = SQ_RAISE;
            SQ_RAISE: if (!vsup_at_low) st_nx = SQ_IDLE;
            default:  st_nx = SQ_IDLE;
        endcase
    end

    // phase register and settle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= (st == SQ_GATE) ? cnt + 1'b1 : '0;
        end
    end

    // outputs decoded from the phase
    always_comb begin
        clk_off    = (st != SQ_IDLE);
        supply_low = (st == SQ_LOWER) || (st == SQ_SLEEP);
        asleep     = (st == SQ_SLEEP);
    end

    // R7
    low_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> clk_off);

    // R7
    sleep_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> supply_low);

    // R7
    gate_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_off) |-> $past(req));

    // R9
    release_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_off) |-> !$past(vsup_at_low));
endmodule

// File: rtl/dsm_entry_ctrl.sv
// Top of the deep sleep entry controller.
// Joins the configuration register, the entry condition and the sequencer.
// Assumes all inputs are synchronous to clk.
module dsm_entry_ctrl
    import dsm_pkg::*;
#(
    parameter int SETTLE = 4,
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_a,
    input  logic [1:0]        mode_b,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_wdata,
    output logic [4:0]        cfg_q,
    output logic              cfg_err,
    input  logic              plls_off,
    input  logic              vsup_at_low,
    input  logic [WAKE_W-1:0] wake_evt,
    input  logic [WAKE_W-1:0] wake_en,
    output logic              dsm_req,
    output logic              clk_off,
    output logic              supply_low,
    output logic              asleep
);
    cfg_t cfg;

    dsm_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .err   (cfg_err)
    );

    // configuration readback
    always_comb cfg_q = cfg;

    dsm_trigger #(.N_DOM(2)) u_trig (
        .mode     ({mode_b, mode_a}),
        .fw_en    ({cfg.fw_b, cfg.fw_a}),
        .mask     ({cfg.msk_b, cfg.msk_a}),
        .en       (cfg.en),
        .plls_off (plls_off),
        .req      (dsm_req)
    );

    dsm_seq #(.SETTLE(SETTLE), .WAKE_W(WAKE_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (dsm_req),
        .vsup_at_low (vsup_at_low),
        .wake_evt    (wake_evt),
        .wake_en     (wake_en),
        .clk_off     (clk_off),
        .supply_low  (supply_low),
        .asleep      (asleep)
    );
endmodule

// File: tb/sim_dsm_entry_ctrl.sv
module sim_dsm_entry_ctrl;
    localparam int CLK_T  = 10;
    localparam int SETTLE = 4;
    localparam int WAKE_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode_a = 2'd0, mode_b = 2'd0;
    logic              cfg_we = 1'b0;
    logic [4:0]        cfg_wdata = '0;
    logic [4:0]        cfg_q;
    logic              cfg_err;
    logic              plls_off = 1'b0;
    logic              vsup_at_low;
    logic [WAKE_W-1:0] wake_evt = '0, wake_en = '0;
    logic              dsm_req, clk_off, supply_low, asleep;
    logic [1:0]        sh = '0;
    logic              hold_low = 1'b0;

    int n_chk = 0, n_bad = 0, cyc_n = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int ph = 0, mcnt = 0;
    logic [4:0] mcfg = '0;
    bit merr = 0;

    always #(CLK_T/2) clk = ~clk;

    // supply stand-in: follows supply_low two cycles late unless held low
    always @(posedge clk) sh <= {sh[0], supply_low};
    assign vsup_at_low = sh[1] | hold_low;

    dsm_entry_ctrl #(.SETTLE(SETTLE), .WAKE_W(WAKE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .cfg_err(cfg_err),
        .plls_off(plls_off), .vsup_at_low(vsup_at_low),
        .wake_evt(wake_evt), .wake_en(wake_en),
        .dsm_req(dsm_req), .clk_off(clk_off), .supply_low(supply_low), .asleep(asleep)
    );

    function automatic bit model_req();
        bit a_st, b_st;
        a_st = (mode_a == 2'd2) && !mcfg[1];
        b_st = (mode_b == 2'd2) && !mcfg[2];
        return mcfg[0] && plls_off &&
               ((a_st && b_st) || (mcfg[4] && a_st) || (mcfg[3] && b_st));
    endfunction

    // behavioural reference, advanced on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; mcnt = 0; mcfg = '0; merr = 0;
        end else begin
            bit r;
            r = model_req();
            case (ph)
                0: if (r) begin ph = 1; mcnt = 0; end
                1: if (!r) ph = 0;
                   else if (mcnt == SETTLE - 1) ph = 2;
                   else mcnt++;
                2: if (vsup_at_low) ph = 3;
                3: if ((wake_evt & wake_en) != 0) ph = 4;
                4: if (!vsup_at_low) ph = 0;
                default: ph = 0;
            endcase
            if (cfg_we) begin
                if (cfg_wdata[3] && cfg_wdata[4]) merr = 1;
                else mcfg = cfg_wdata;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "dsm_req", int'(dsm_req), int'(model_req()));
            chk(cur_req, "clk_off", int'(clk_off), int'(ph != 0));
            chk(cur_req, "supply_low", int'(supply_low), int'(ph == 2 || ph == 3));
            chk(cur_req, "asleep", int'(asleep), int'(ph == 3));
            chk(cur_req, "cfg_q", int'(cfg_q), int'(mcfg));
            chk(cur_req, "cfg_err", int'(cfg_err), int'(merr));
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc_n);
            summary();
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        step(3);
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset clk_off", int'(clk_off), 0);
        chk("R1", "reset supply_low", int'(supply_low), 0);
        chk("R1", "reset asleep", int'(asleep), 0);
        chk("R1", "reset cfg_q", int'(cfg_q), 0);
        chk("R1", "reset cfg_err", int'(cfg_err), 0);
        chk("R1", "reset dsm_req", int'(dsm_req), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        step(2);

        // R10: one domain running keeps request low
        cur_req = "R10";
        wr(5'b00001); plls_off = 1'b1;
        mode_a = 2'd2; mode_b = 2'd0; step(3);
        chk("R10", "B run", int'(dsm_req), 0);
        mode_b = 2'd1; step(3);
        chk("R10", "B wait", int'(dsm_req), 0);
        mode_b = 2'd3; step(2);
        chk("R10", "B code 3", int'(dsm_req), 0);

        // R3: fast-wake-up stop does not count
        cur_req = "R3";
        mode_b = 2'd2; wr(5'b00011); step(3);
        chk("R3", "A fast stop", int'(clk_off), 0);
        wr(5'b00101); step(3);
        chk("R3", "B fast stop", int'(clk_off), 0);

        // R4: clock generators must be closed
        cur_req = "R4";
        plls_off = 1'b0; wr(5'b00001); step(3);
        chk("R4", "plls on", int'(dsm_req), 0);
        chk("R4", "plls on no gate", int'(clk_off), 0);

        // R2 and R7: full entry
        cur_req = "R7";
        plls_off = 1'b1; #1;
        chk("R2", "both stop", int'(dsm_req), 1);
        step(1);
        chk("R7", "gate one cycle later", int'(clk_off), 1);
        step(SETTLE);
        chk("R7", "supply lowered", int'(supply_low), 1);
        step(4);
        chk("R7", "asleep", int'(asleep), 1);

        // R9: disabled wake ignored, then held supply keeps clocks gated
        cur_req = "R9";
        mode_a = 2'd0; mode_b = 2'd0;
        wake_en = 4'b0001; wake_evt = 4'b0110; step(1);
        wake_evt = '0; step(2);
        chk("R9", "masked wake", int'(asleep), 1);
        hold_low = 1'b1;
        wake_evt = 4'b0001; step(1);
        wake_evt = '0; step(5);
        chk("R9", "supply raised", int'(supply_low), 0);
        chk("R9", "clocks held", int'(clk_off), 1);
        hold_low = 1'b0; step(4);
        chk("R9", "clocks released", int'(clk_off), 0);

        // R8: abort during gating
        cur_req = "R8";
        mode_a = 2'd2; mode_b = 2'd2; step(2);
        chk("R8", "gating", int'(clk_off), 1);
        mode_b = 2'd0; step(1);
        chk("R8", "abort", int'(clk_off), 0);
        step(SETTLE + 3);
        chk("R8", "never lowered", int'(supply_low), 0);

        // R5: single-domain triggers
        cur_req = "R5";
        mode_a = 2'd2; mode_b = 2'd0; wr(5'b10001); #1;
        chk("R5", "mask B, A alone", int'(dsm_req), 1);
        mode_a = 2'd0; step(1);
        mode_b = 2'd2; wr(5'b01001); #1;
        chk("R5", "mask A, B alone", int'(dsm_req), 1);
        mode_b = 2'd1; mode_a = 2'd2; step(1);
        chk("R5", "mask A, A alone", int'(dsm_req), 0);

        // R6: both masks refused
        cur_req = "R6";
        wr(5'b11001); step(1);
        chk("R6", "cfg kept", int'(cfg_q), 5'b01001);
        chk("R6", "err set", int'(cfg_err), 1);
        wr(5'b00000); step(2);
        chk("R6", "err sticky", int'(cfg_err), 1);
        step(3);
        summary();
    end
endmodule